// File: doc/BRIEF.md
# UART Special-Event Interrupt Flags

This block sits behind a UART receiver and turns a handful of noteworthy receive-side events into sticky interrupt flags. Four flags come from comparing each received character against four programmable flow-control codes (two "resume" codes and two "pause" codes). One flag comes from a multidrop address character, marked by the ninth data bit. One flag comes from a line break, which is the RX line held low for longer than one whole character frame.

Host software reads the flags through a simple register-read port at a fixed address. That read returns the flag byte and clears every flag. A per-flag enable mask folds the flags into one summary interrupt line, which the surrounding logic feeds into its global interrupt status. Character matching is gated by a detection-enable mode bit. Address-character flagging is gated by a multidrop mode bit.

Top module: `uart_evt_flags`

## Requirements
- R1: After reset every flag is 0, a read of the flag register returns 0x00 and `spc_irq` is 0.
- R2: The flag byte has this layout: bit 0 resume code 1, bit 1 resume code 2, bit 2 pause code 1, bit 3 pause code 2, bit 4 break, bit 5 multidrop address. Bits 7 and 6 always read 0.
- R3: While `spc_det_en` is 1, a strobed character (`rx_vld` = 1) equal to one of `xon1_val`, `xon2_val`, `xoff1_val` or `xoff2_val` sets the matching flag on that clock edge. A character that equals several compare values sets all of them.
- R4: While `spc_det_en` is 0, no received character sets any of flags 3..0.
- R5: While `md_mode_en` is 1, a strobed character with `rx_addr_bit` = 1 sets flag 5. A character with `rx_addr_bit` = 0 never sets it. While `md_mode_en` is 0, `rx_addr_bit` is ignored.
- R6: Flag 4 sets on the (`frame_bits`+1)-th `bit_tick` seen while `rx_line` stays low. A low period of `frame_bits` ticks or fewer sets nothing.
- R7: A single low period sets the break flag at most once. After a clearing read, further ticks in the same low period do not set it again. The detector re-arms only after `rx_line` returns high.
- R8: Asserting `rd_en` with `rd_addr` equal to 6 returns the flag byte on `rd_data` in the same cycle and clears all flags at the next edge. A read at any other address returns 0x00 and leaves the flags unchanged.
- R9: When an event occurs in the same cycle as a clearing read, the event's flag is set after the read.
- R10: `spc_irq` is 1 exactly when some flag n is set and `irq_mask[n]` is 1.
- R11: A flag, once set, stays set until a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_vld | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received character |
| rx_addr_bit | input | 1 | Ninth data bit of the received character |
| rx_line | input | 1 | Synchronised RX line sample |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| md_mode_en | input | 1 | Multidrop address detection enable |
| spc_det_en | input | 1 | Special character detection enable |
| frame_bits | input | 4 | Bits per frame (start + data + parity + stop) |
| xon1_val | input | 8 | Resume code 1 |
| xon2_val | input | 8 | Resume code 2 |
| xoff1_val | input | 8 | Pause code 1 |
| xoff2_val | input | 8 | Pause code 2 |
| irq_mask | input | 6 | Per-flag summary enable, bit n for flag n |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data |
| spc_irq | output | 1 | Summary interrupt |

## Verification
The assertions assume that `rx_vld`, `bit_tick` and `rd_en` are single-cycle synchronous strobes, and that the mode bits and compare values stay stable while characters are being strobed. The stimulus changes inputs only on the falling clock edge. It keeps `rx_line` high during character sweeps and holds the configuration constant across each sweep. Ticks arrive one every four cycles, so each low period spans a known number of ticks.

// File: rtl/uart_evt_pkg.sv
// Package: shared flag indices and vector type for the special-event block.
// Assumes six flags; index order is the software-visible bit order.
package uart_evt_pkg;
    localparam int NUM_FLAGS = 6;
    localparam int NUM_CMP   = 4;
    localparam int FL_XON1   = 0;
    localparam int FL_XON2   = 1;
    localparam int FL_XOFF1  = 2;
    localparam int FL_XOFF2  = 3;
    localparam int FL_BREAK  = 4;
    localparam int FL_MDROP  = 5;
    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/uart_evt_cmp_bank.sv
// Comparator bank: compares one strobed character against NCMP programmed
// codes in parallel. Assumes compare values are stable while strobed.
module uart_evt_cmp_bank #(
    parameter int DATA_W = 8,
    parameter int NCMP   = 4
) (
    input  logic                   chr_vld,
    input  logic                   det_en,
    input  logic [DATA_W-1:0]      chr,
    input  logic [NCMP*DATA_W-1:0] codes,
    output logic [NCMP-1:0]        hit
);
    // One equality comparator per programmed code, qualified by strobe and enable.
    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        always_comb hit[g] = chr_vld && det_en && (chr == codes[g*DATA_W +: DATA_W]);
    end
endmodule

// File: rtl/uart_evt_brk_det.sv
// Break detector: counts bit ticks while the line is low and pulses once
// when the count exceeds the frame length. Re-arms when the line goes high.
// Assumes bit_tick is a one-cycle pulse and line is already synchronised.
module uart_evt_brk_det #(
    parameter int FRM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             bit_tick,
    input  logic [FRM_W-1:0] frame_bits,
    output logic             brk_evt
);
    localparam int CNT_W = FRM_W + 1;

    logic [CNT_W-1:0] low_cnt;
    logic             fired;

    // Pulse on the tick that makes the low time exceed one frame.
    always_comb brk_evt = !line && bit_tick && !fired && (low_cnt >= CNT_W'(frame_bits));

    // Track ticks spent low and remember that this low period already fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            fired   <= 1'b0;
        end else if (line) begin
            low_cnt <= '0;
            fired   <= 1'b0;
        end else if (bit_tick && !fired) begin
            if (low_cnt >= CNT_W'(frame_bits)) fired   <= 1'b1;
            else                               low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_evt_sticky.sv
// Sticky flag register: bits set on events, all cleared by a read strobe.
// A set in the same cycle as a clear takes priority so no event is lost.
module uart_evt_sticky #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags
);
    // Hold, clear on read, and OR in new events last so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr ? '0 : flags) | evt;
    end
endmodule

// File: rtl/uart_evt_flags.sv
// Top: special-event interrupt flags for a UART receive path.
// Gathers comparator, multidrop and break events into a clear-on-read
// flag byte and a masked summary interrupt. Assumes all inputs are
// synchronous to clk and strobes last one cycle.
module uart_evt_flags
    import uart_evt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FRM_W     = 4,
    parameter int ADDR_W    = 4,
    parameter int FLAG_ADDR = 6,
    parameter int RD_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_vld,
    input  logic [DATA_W-1:0]    rx_data,
    input  logic                 rx_addr_bit,
    input  logic                 rx_line,
    input  logic                 bit_tick,
    input  logic                 md_mode_en,
    input  logic                 spc_det_en,
    input  logic [FRM_W-1:0]     frame_bits,
    input  logic [DATA_W-1:0]    xon1_val,
    input  logic [DATA_W-1:0]    xon2_val,
    input  logic [DATA_W-1:0]    xoff1_val,
    input  logic [DATA_W-1:0]    xoff2_val,
    input  logic [NUM_FLAGS-1:0] irq_mask,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [RD_W-1:0]      rd_data,
    output logic                 spc_irq
);
    localparam int PAD_W = RD_W - NUM_FLAGS;

    logic [NUM_CMP-1:0] cmp_hit;
    logic               brk_evt;
    logic               md_evt;
    logic               rd_hit;
    flag_vec_t          evt;
    flag_vec_t          flags;

    uart_evt_cmp_bank #(.DATA_W(DATA_W), .NCMP(NUM_CMP)) u_cmp (
        .chr_vld (rx_vld),
        .det_en  (spc_det_en),
        .chr     (rx_data),
        .codes   ({xoff2_val, xoff1_val, xon2_val, xon1_val}),
        .hit     (cmp_hit)
    );

    uart_evt_brk_det #(.FRM_W(FRM_W)) u_brk (
        .clk        (clk),
        .rst_n      (rst_n),
        .line       (rx_line),
        .bit_tick   (bit_tick),
        .frame_bits (frame_bits),
        .brk_evt    (brk_evt)
    );

    // Address character only counts in multidrop mode.
    always_comb md_evt = rx_vld && md_mode_en && rx_addr_bit;

    // Assemble the event vector in flag-bit order.
    always_comb begin
        evt                    = '0;
        evt[FL_XOFF2:FL_XON1]  = cmp_hit;
        evt[FL_BREAK]          = brk_evt;
        evt[FL_MDROP]          = md_evt;
    end

    // Decode a read of the flag register.
    always_comb rd_hit = rd_en && (rd_addr == ADDR_W'(FLAG_ADDR));

    uart_evt_sticky #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (rd_hit),
        .flags (flags)
    );

    // Return flags with unused upper bits zero; other addresses read zero.
    always_comb rd_data = rd_hit ? {{PAD_W{1'b0}}, flags} : '0;

    // Summary interrupt: any enabled flag.
    always_comb spc_irq = |(flags & irq_mask);
endmodule

// File: rtl/uart_evt_flags_chk.sv
// Checker: temporal properties of the special-event flag block.
// Bound to every uart_evt_flags instance.
module uart_evt_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spc_det_en,
    input logic       md_mode_en,
    input logic       rd_hit,
    input logic       brk_evt,
    input logic [5:0] evt,
    input logic [5:0] flags,
    input logic       spc_irq
);
    // R4: no new comparator flag while detection is off
    a_r4_det_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !spc_det_en |=> ((flags[3:0] & ~$past(flags[3:0])) == 4'b0));

    // R5: no new multidrop flag while multidrop mode is off
    a_r5_md_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !md_mode_en |=> (!flags[5] || $past(flags[5])));

    // R7: a break pulse is never followed directly by another
    a_r7_single_break: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> !brk_evt);

    // R8: after a clearing read only same-cycle events remain
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> ((flags & ~$past(evt)) == 6'b0));

    // R9: events always land in the flags
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != 6'b0) |=> ((flags & $past(evt)) == $past(evt)));

    // R11: without a read no flag drops
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (($past(flags) & ~flags) == 6'b0));

    // R10: no flags means no summary interrupt
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 6'b0) |-> !spc_irq);
endmodule

bind uart_evt_flags uart_evt_flags_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spc_det_en (spc_det_en),
    .md_mode_en (md_mode_en),
    .rd_hit     (rd_hit),
    .brk_evt    (brk_evt),
    .evt        (evt),
    .flags      (flags),
    .spc_irq    (spc_irq)
);

// File: tb/uart_evt_flags_test.sv
// Bench: sweeps characters, break lengths and masks against arithmetic
// expectations for the special-event flag block.
module uart_evt_flags_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] C_XON1  = 8'h11;
    localparam logic [7:0] C_XON2  = 8'h91;
    localparam logic [7:0] C_XOFF1 = 8'h13;
    localparam logic [7:0] C_XOFF2 = 8'h93;
    localparam int FRAME = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_addr_bit = 1'b0;
    logic       rx_line = 1'b1;
    logic       bit_tick = 1'b0;
    logic       md_mode_en = 1'b0;
    logic       spc_det_en = 1'b0;
    logic [3:0] frame_bits = 4'(FRAME);
    logic [5:0] irq_mask = 6'h00;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = 4'h0;
    logic [7:0] rd_data;
    logic       spc_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] v;

    uart_evt_flags uut (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_data(rx_data),
        .rx_addr_bit(rx_addr_bit), .rx_line(rx_line), .bit_tick(bit_tick),
        .md_mode_en(md_mode_en), .spc_det_en(spc_det_en), .frame_bits(frame_bits),
        .xon1_val(C_XON1), .xon2_val(C_XON2), .xoff1_val(C_XOFF1), .xoff2_val(C_XOFF2),
        .irq_mask(irq_mask), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .spc_irq(spc_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        step();
        rd_en = 1'b0;
    endtask

    task automatic send_chr(input logic [7:0] c, input logic b9);
        rx_vld = 1'b1; rx_data = c; rx_addr_bit = b9;
        step();
        rx_vld = 1'b0; rx_addr_bit = 1'b0;
    endtask

    task automatic hold_low(input int n);
        rx_line = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; step(); bit_tick = 1'b0;
            step(); step(); step();
        end
    endtask

    function automatic logic [7:0] exp_chr(input logic [7:0] c);
        return {4'b0, c == C_XOFF2, c == C_XOFF1, c == C_XON2, c == C_XON1};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        #1 chk(spc_irq == 1'b0, "R1 irq", int'(spc_irq), 0);
        read_reg(4'd6, v);
        chk(v == 8'h00, "R1 flags", int'(v), 0);

        // R3 R2: sweep all characters with detection on, addr bit ignored (R5)
        spc_det_en = 1'b1;
        for (int c = 0; c < 256; c++) begin
            send_chr(8'(c), c[0]);
            read_reg(4'd6, v);
            chk(v == exp_chr(8'(c)), "R3 char match", int'(v), int'(exp_chr(8'(c))));
        end

        // R4: detection off, no flag for any character
        spc_det_en = 1'b0;
        for (int c = 0; c < 256; c++) begin
            send_chr(8'(c), 1'b0);
            read_reg(4'd6, v);
            chk(v == 8'h00, "R4 det off", int'(v), 0);
        end

        // R5: multidrop address bit
        md_mode_en = 1'b1;
        send_chr(8'h40, 1'b1);
        read_reg(4'd6, v);
        chk(v == 8'h20, "R5 address char", int'(v), 32'h20);
        send_chr(8'h40, 1'b0);
        read_reg(4'd6, v);
        chk(v == 8'h00, "R5 data char", int'(v), 0);
        md_mode_en = 1'b0;
        send_chr(8'h40, 1'b1);
        read_reg(4'd6, v);
        chk(v == 8'h00, "R5 mode off", int'(v), 0);

        // R6: low periods of 1..14 ticks
        for (int n = 1; n <= 14; n++) begin
            hold_low(n);
            rx_line = 1'b1; step();
            read_reg(4'd6, v);
            chk(v == ((n > FRAME) ? 8'h10 : 8'h00), "R6 break length", int'(v),
                (n > FRAME) ? 32'h10 : 0);
        end

        // R7: one break per low period, re-arm after high
        hold_low(30);
        read_reg(4'd6, v);
        chk(v == 8'h10, "R7 first break", int'(v), 32'h10);
        hold_low(12);
        read_reg(4'd6, v);
        chk(v == 8'h00, "R7 no refire", int'(v), 0);
        rx_line = 1'b1; step();
        hold_low(FRAME + 1);
        rx_line = 1'b1; step();
        read_reg(4'd6, v);
        chk(v == 8'h10, "R7 rearm", int'(v), 32'h10);

        // R8: other address neither returns nor clears; R11 sticky over idle
        spc_det_en = 1'b1;
        send_chr(C_XOFF1, 1'b0);
        repeat (5) step();
        read_reg(4'd5, v);
        chk(v == 8'h00, "R8 other addr", int'(v), 0);
        read_reg(4'd6, v);
        chk(v == 8'h04, "R11 sticky", int'(v), 32'h04);
        read_reg(4'd6, v);
        chk(v == 8'h00, "R8 cleared", int'(v), 0);

        // R9: event in the same cycle as the clearing read
        send_chr(C_XON2, 1'b0);
        rd_en = 1'b1; rd_addr = 4'd6;
        rx_vld = 1'b1; rx_data = C_XON1;
        #1 v = rd_data;
        chk(v == 8'h02, "R9 read value", int'(v), 32'h02);
        step();
        rd_en = 1'b0; rx_vld = 1'b0;
        read_reg(4'd6, v);
        chk(v == 8'h01, "R9 event kept", int'(v), 32'h01);

        // R10: each flag against every mask
        md_mode_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            for (int m = 0; m < 64; m++) begin
                irq_mask = 6'(m);
                case (k)
                    0: send_chr(C_XON1, 1'b0);
                    1: send_chr(C_XON2, 1'b0);
                    2: send_chr(C_XOFF1, 1'b0);
                    3: send_chr(C_XOFF2, 1'b0);
                    4: begin hold_low(FRAME + 1); rx_line = 1'b1; step(); end
                    default: send_chr(8'h00, 1'b1);
                endcase
                #1 chk(spc_irq == m[k], "R10 mask", int'(spc_irq), int'(m[k]));
                read_reg(4'd6, v);
                #1 chk(spc_irq == 1'b0, "R10 after clear", int'(spc_irq), 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule